// File: doc/BRIEF.md
# Clamped PWM Modulator with External Sync

This block turns a digital duty word into a single PWM output for a switching converter. A cycle counter running on a 25 MHz clock (40 ns per tick) sets the switching period. The on-time is taken from the duty word and then limited by two programmable clamps. A minimum low time per cycle caps the largest duty. A minimum pulse width raises any small nonzero pulse. When the two clamps disagree, the low-time clamp wins. A mode bit places the pulse either at the start of the cycle or at its end. A current-limit input ends the active pulse at once, and it has no further effect until the next cycle begins.

A sync input can also set the cycle timing. The block measures the time between divided rising edges of the sync input, where the divider is 1, 2, 3 or 4. When that time lies within ±12.5% of the programmed period, the block locks and starts each switching cycle on a divided sync edge. When it does not, the internal period stays in use. Duty, period and clamps are taken only at the start of a cycle, so a mid-cycle change never produces a runt pulse.

Top module: `pwm_clamp_mod`

## Requirements
- R1: The on-time in a cycle never exceeds the cycle length minus 1+2k ticks, where k is the 4-bit low-clamp code. For example, code 0 with a 100-tick period lets at most 99 ticks through, and code 5 lets at most 89.
- R2: A nonzero duty word below 2m ticks (m being the 4-bit high-clamp code) yields a 2m-tick pulse. A duty word of 0 yields no pulse at all.
- R3: When the stretched minimum pulse conflicts with the low-time clamp, the pulse is cut to the low-time limit.
- R4: With mode bit 0 (trailing), the pulse begins at cycle count 0, and the first cycle begins on the first clock edge after reset is released. With mode bit 1 (leading), the pulse occupies the last on-time ticks of the cycle. The output is low during reset.
- R5: Duty, period and clamp words are latched only at cycle start. A change made mid-cycle leaves the current pulse unchanged and applies to the next one.
- R6: A high current-limit input forces the output low from the next clock edge to the end of the current cycle. The output resumes normal pulses in the following cycle.
- R7: With sync enabled, the block locks after two consecutive divided sync periods that each satisfy 7·P ≤ 8·T ≤ 9·P (P being the programmed period and T the measured period, both in ticks). Once locked, each cycle starts on a divided sync rising edge. A single period outside this window, or disabling sync, drops the lock and returns the block to free running at P.
- R8: The 2-bit divider code d makes the block count d+1 sync rising edges per switching cycle, so the locked switching period is (d+1) sync periods.
- R9: When not locked, the switching period equals the period word in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_i | input | CNT_W | Requested on-time in ticks |
| period_i | input | CNT_W | Switching period in ticks |
| min_off_code_i | input | CODE_W | Low-time clamp code k (1+2k ticks) |
| min_on_code_i | input | CODE_W | Minimum pulse code m (2m ticks) |
| lead_edge_i | input | 1 | 0 = trailing-edge, 1 = leading-edge |
| sync_en_i | input | 1 | Allow locking to the sync input |
| sync_div_i | input | 2 | Sync division code d (divide by d+1) |
| sync_i | input | 1 | External sync clock (asynchronous) |
| ilim_i | input | 1 | Current-limit comparator, active high |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The properties assume that the current-limit input is already synchronous to the clock. They also assume that the period word is nonzero while the range check on the counter applies. The bench drives every input, including the sync wave, on falling clock edges. It keeps the period fixed while a measurement runs, and gives each new sync rate several divided periods to settle before it times the gap between rising edges. Window boundaries are exercised with integer sync periods just inside and just outside the ±12.5% limits.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;
  typedef enum logic {
    EDGE_TRAIL = 1'b0,
    EDGE_LEAD  = 1'b1
  } edge_mode_e;

  localparam int DIV_CODE_W = 2;
endpackage

// File: rtl/pwm_sync_track.sv
module pwm_sync_track #(
  parameter int CNT_W = 12,
  parameter int PW    = CNT_W + 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en,
  input  logic [pwm_mod_pkg::DIV_CODE_W-1:0] div,
  input  logic                              sync_in,
  input  logic [CNT_W-1:0]                  period,
  output logic                              restart,
  output logic [PW-1:0]                     cap,
  output logic                              locked
);
  localparam int WW = PW + 4;

  logic       s1, s2, s3;
  logic       rise, div_edge, primed, seen, inwin, timeout;
  logic [pwm_mod_pkg::DIV_CODE_W-1:0] edge_cnt;
  logic [PW-1:0] meas;
  logic [WW-1:0] cap8, meas8, lo_lim, hi_lim;

  assign rise     = s2 & ~s3;
  assign div_edge = rise && (edge_cnt >= div);
  assign cap      = (&meas) ? meas : meas + PW'(1);
  assign cap8     = WW'({cap, 3'b000});
  assign meas8    = WW'({meas, 3'b000});
  assign lo_lim   = WW'(period) * WW'(7);
  assign hi_lim   = WW'(period) * WW'(9);
  assign inwin    = (cap8 >= lo_lim) && (cap8 <= hi_lim);
  assign timeout  = primed && (meas8 > hi_lim);
  assign restart  = en && div_edge && primed && inwin && (seen || locked);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sync_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      edge_cnt <= '0;
      meas     <= '0;
      primed   <= 1'b0;
      seen     <= 1'b0;
      locked   <= 1'b0;
    end else begin
      if (rise) edge_cnt <= div_edge ? '0 : edge_cnt + 1'b1;
      if (div_edge) begin
        meas   <= '0;
        primed <= 1'b1;
        if (primed) begin
          if (inwin) begin
            seen   <= 1'b1;
            locked <= locked | seen;
          end else begin
            seen   <= 1'b0;
            locked <= 1'b0;
          end
        end
      end else if (timeout) begin
        meas   <= '0;
        primed <= 1'b0;
        seen   <= 1'b0;
        locked <= 1'b0;
      end else if (!(&meas)) begin
        meas <= meas + PW'(1);
      end
    end
  end

  // R7: lock can only be gained on a divided sync edge
  a_r7_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(div_edge));
  // R7: disabling sync drops the lock
  a_r7_disable_drops: assert property (@(posedge clk) disable iff (rst)
    !en |=> !locked);
  // R8: a sync-driven restart leaves the tracker locked
  a_r8_restart_locked: assert property (@(posedge clk) disable iff (rst)
    restart |=> locked);
endmodule

// File: rtl/pwm_duty_clamp.sv
module pwm_duty_clamp #(
  parameter int CNT_W  = 12,
  parameter int CODE_W = 4,
  parameter int PW     = CNT_W + 1
) (
  input  logic [CNT_W-1:0]  duty,
  input  logic [PW-1:0]     plen,
  input  logic [CODE_W-1:0] off_code,
  input  logic [CODE_W-1:0] on_code,
  output logic [PW-1:0]     on_ticks
);
  logic [PW-1:0] min_off, min_on, max_on, stretched;

  always_comb begin
    min_off   = PW'(1) + (PW'(off_code) << 1);
    min_on    = PW'(on_code) << 1;
    max_on    = (plen > min_off) ? plen - min_off : '0;
    stretched = ((duty != '0) && (PW'(duty) < min_on)) ? min_on : PW'(duty);
    on_ticks  = (stretched > max_on) ? max_on : stretched;
  end
endmodule

// File: rtl/pwm_cycle_core.sv
module pwm_cycle_core #(
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          locked,
  input  logic          sync_restart,
  input  logic [PW-1:0] plen_in,
  input  logic [PW-1:0] on_in,
  input  pwm_mod_pkg::edge_mode_e mode,
  input  logic          ilim,
  output logic          pwm_q
);
  logic [PW-1:0] cnt, plen_r, on_r, cnt_n, plen_n, on_n;
  logic          term, term_n, cycle_start, want;
  logic [PW:0]   cnt_inc, lead_sum;

  always_comb begin
    cnt_inc     = {1'b0, cnt} + (PW+1)'(1);
    cycle_start = sync_restart || (!locked && (cnt_inc >= {1'b0, plen_r}));
    if (cycle_start)   cnt_n = '0;
    else if (&cnt)     cnt_n = cnt;
    else               cnt_n = cnt + PW'(1);
    plen_n   = cycle_start ? plen_in : plen_r;
    on_n     = cycle_start ? on_in   : on_r;
    term_n   = (cycle_start ? 1'b0 : term) | ilim;
    lead_sum = {1'b0, cnt_n} + {1'b0, on_n};
    if (mode == pwm_mod_pkg::EDGE_LEAD)
      want = (on_n != '0) && (lead_sum >= {1'b0, plen_n});
    else
      want = cnt_n < on_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      plen_r <= '0;
      on_r   <= '0;
      term   <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      plen_r <= plen_n;
      on_r   <= on_n;
      term   <= term_n;
      pwm_q  <= want & ~term_n;
    end
  end

  // R6: a current-limit event forces the output low on the next edge
  a_r6_ilim_low: assert property (@(posedge clk) disable iff (rst)
    ilim |=> !pwm_q);
  // R9: while free running the counter stays inside the latched period
  a_r9_cnt_range: assert property (@(posedge clk) disable iff (rst)
    (!locked && !$past(locked) && plen_r != '0) |-> (cnt < plen_r));
endmodule

// File: rtl/pwm_clamp_mod.sv
module pwm_clamp_mod #(
  parameter int CNT_W  = 12,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  duty_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CODE_W-1:0] min_off_code_i,
  input  logic [CODE_W-1:0] min_on_code_i,
  input  logic              lead_edge_i,
  input  logic              sync_en_i,
  input  logic [1:0]        sync_div_i,
  input  logic              sync_i,
  input  logic              ilim_i,
  output logic              pwm_o
);
  localparam int PW = CNT_W + 1;

  logic          restart, locked;
  logic [PW-1:0] cap, plen_next, on_next;
  pwm_mod_pkg::edge_mode_e mode;

  assign mode      = pwm_mod_pkg::edge_mode_e'(lead_edge_i);
  assign plen_next = restart ? cap : PW'(period_i);

  pwm_sync_track #(.CNT_W(CNT_W), .PW(PW)) u_track (
    .clk(clk), .rst(rst), .en(sync_en_i), .div(sync_div_i),
    .sync_in(sync_i), .period(period_i),
    .restart(restart), .cap(cap), .locked(locked)
  );

  pwm_duty_clamp #(.CNT_W(CNT_W), .CODE_W(CODE_W), .PW(PW)) u_clamp (
    .duty(duty_i), .plen(plen_next), .off_code(min_off_code_i),
    .on_code(min_on_code_i), .on_ticks(on_next)
  );

  pwm_cycle_core #(.PW(PW)) u_core (
    .clk(clk), .rst(rst), .locked(locked), .sync_restart(restart),
    .plen_in(plen_next), .on_in(on_next), .mode(mode),
    .ilim(ilim_i), .pwm_q(pwm_o)
  );
endmodule

// File: tb/pwm_clamp_mod_tb.sv
module pwm_clamp_mod_tb;
  localparam int CLK_NS = 40;
  localparam int CNT_W  = 12;
  localparam int CODE_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0]  duty_i = 30, period_i = 100;
  logic [CODE_W-1:0] min_off_code_i = 0, min_on_code_i = 0;
  logic lead_edge_i = 0, sync_en_i = 0, sync_i = 0, ilim_i = 0;
  logic [1:0] sync_div_i = 0;
  logic pwm_o;

  int checks = 0, fails = 0;
  int sync_per = 100;
  bit sync_run = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwm_clamp_mod #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst(rst), .duty_i(duty_i), .period_i(period_i),
    .min_off_code_i(min_off_code_i), .min_on_code_i(min_on_code_i),
    .lead_edge_i(lead_edge_i), .sync_en_i(sync_en_i), .sync_div_i(sync_div_i),
    .sync_i(sync_i), .ilim_i(ilim_i), .pwm_o(pwm_o)
  );

  initial begin
    forever begin
      if (sync_run) begin
        sync_i = 1'b1;
        repeat (sync_per / 2) @(negedge clk);
        sync_i = 1'b0;
        repeat (sync_per - sync_per / 2) @(negedge clk);
      end else begin
        sync_i = 1'b0;
        @(negedge clk);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = pwm_o;
    forever begin
      @(negedge clk);
      if (pwm_o && !p) break;
      p = pwm_o;
    end
  endtask

  task automatic width_hi(output int w);
    wait_rise();
    w = 1;
    forever begin
      @(negedge clk);
      if (!pwm_o) break;
      w++;
    end
  endtask

  task automatic rise_gap(output int g);
    logic p;
    wait_rise();
    g = 0;
    p = 1'b1;
    forever begin
      @(negedge clk);
      g++;
      if (pwm_o && !p) break;
      p = pwm_o;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 reset low", int'(pwm_o), 0);
    rst = 1'b0;
  endtask

  task automatic first_high(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pwm_o && n < 500);
  endtask

  task automatic t_trailing();
    int n, w, g;
    lead_edge_i = 0; duty_i = 30; period_i = 100;
    min_off_code_i = 0; min_on_code_i = 0;
    do_reset();
    first_high(n);
    check("R4 trailing first pulse", n, 1);
    width_hi(w);
    check("R4 trailing width", w, 30);
    rise_gap(g);
    check("R9 free period", g, 100);
    period_i = 60;
    wait_rise();
    rise_gap(g);
    check("R9 period 60", g, 60);
    period_i = 100;
  endtask

  task automatic t_leading();
    int n, w;
    lead_edge_i = 1; duty_i = 30; period_i = 100;
    do_reset();
    first_high(n);
    check("R4 leading first pulse", n, 71);
    width_hi(w);
    check("R4 leading width", w, 30);
    lead_edge_i = 0;
  endtask

  task automatic t_min_off();
    int w;
    period_i = 100; min_on_code_i = 0;
    min_off_code_i = 0; duty_i = 100;
    wait_rise(); width_hi(w);
    check("R1 code0 cap", w, 99);
    min_off_code_i = 5; duty_i = 99;
    wait_rise(); width_hi(w);
    check("R1 code5 cap", w, 89);
    duty_i = 4000;
    wait_rise(); width_hi(w);
    check("R1 oversized duty", w, 89);
    min_off_code_i = 0;
  endtask

  task automatic t_min_on();
    int w, hi;
    period_i = 100; min_off_code_i = 0;
    min_on_code_i = 4; duty_i = 3;
    wait_rise(); width_hi(w);
    check("R2 stretched", w, 8);
    duty_i = 9;
    wait_rise(); width_hi(w);
    check("R2 above min", w, 9);
    duty_i = 0;
    repeat (110) @(negedge clk);
    hi = 0;
    repeat (250) begin
      @(negedge clk);
      if (pwm_o) hi++;
    end
    check("R2 zero duty no pulse", hi, 0);
    min_on_code_i = 0;
  endtask

  task automatic t_conflict();
    int w;
    period_i = 20; min_off_code_i = 7; min_on_code_i = 7; duty_i = 5;
    repeat (120) @(negedge clk);
    width_hi(w);
    check("R3 min-off wins", w, 5);
    period_i = 100; min_off_code_i = 0; min_on_code_i = 0;
  endtask

  task automatic t_latch();
    int w;
    duty_i = 30; period_i = 100;
    wait_rise(); wait_rise();
    repeat (4) @(negedge clk);
    duty_i = 60;
    w = 5;
    forever begin
      @(negedge clk);
      if (!pwm_o) break;
      w++;
    end
    check("R5 mid-cycle change held", w, 30);
    width_hi(w);
    check("R5 next cycle uses new duty", w, 60);
    duty_i = 30;
  endtask

  task automatic t_ilim();
    int g, w;
    duty_i = 50; period_i = 100;
    wait_rise(); wait_rise();
    repeat (9) @(negedge clk);
    check("R6 still high before trip", int'(pwm_o), 1);
    ilim_i = 1'b1;
    @(negedge clk);
    ilim_i = 1'b0;
    check("R6 terminated", int'(pwm_o), 0);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!pwm_o && g < 500);
    check("R6 low to cycle end", g, 90);
    w = 1;
    forever begin
      @(negedge clk);
      if (!pwm_o) break;
      w++;
    end
    check("R6 resumes full width", w, 50);
    duty_i = 30;
  endtask

  task automatic sync_case(input string req, input int ts, input int dv, input int exp);
    int g;
    sync_per = ts; sync_div_i = 2'(dv); sync_run = 1; sync_en_i = 1;
    repeat (ts * (dv + 1) * 6 + 300) @(negedge clk);
    rise_gap(g);
    rise_gap(g);
    check(req, g, exp);
  endtask

  task automatic t_sync();
    int g;
    duty_i = 30; period_i = 100; lead_edge_i = 0;
    sync_case("R7 lock at 104", 104, 0, 104);
    sync_case("R7 out-of-window 87 falls back", 87, 0, 100);
    sync_case("R7 edge 88 locks", 88, 0, 88);
    sync_case("R7 edge 112 locks", 112, 0, 112);
    sync_case("R7 edge 113 falls back", 113, 0, 100);
    sync_case("R8 divide by 2", 52, 1, 104);
    sync_case("R8 divide by 4", 24, 3, 96);
    sync_case("R8 divide by 3", 35, 2, 105);
    sync_en_i = 0;
    repeat (400) @(negedge clk);
    rise_gap(g);
    check("R7 disable returns to period", g, 100);
    sync_run = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_trailing();
    t_leading();
    t_min_off();
    t_min_on();
    t_conflict();
    t_latch();
    t_ilim();
    t_sync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule